// File: doc/BRIEF.md
# Two-Source Event Interrupt Controller

This block gathers two event sources from a data-acquisition engine and presents them to a higher-level interrupt aggregator as one level-sensitive interrupt line. The two sources are a trigger event and an acquisition-complete event. Each source is delivered as a single-cycle pulse. A trigger pulse only counts while the acquisition engine reports that it is armed and waiting for a trigger.

Software controls the block through a small word-addressed register port. A write-one-to-set enable register unmasks sources, and a write-one-to-clear disable register masks them. A read-only register reports the current mask. A status register shows which sources are pending, and writing a one to a status bit clears that bit.

An event latches its pending bit whether or not the source is enabled. The mask only gates the output. The interrupt line is the registered OR of all pending-and-enabled bits.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, the mask register reads 0, the status register reads 0 and `irq_o` is low.
- R2: Source bit positions are fixed: bit 0 is the trigger source and bit 1 is the acquisition-complete source. This applies to the enable, disable, mask and status registers. Register offsets are 0 for enable, 1 for disable, 2 for mask and 3 for status.
- R3: A pulse on `trig_evt_i` sets pending bit 0 only when `trig_armed_i` is high in the same cycle. When `trig_armed_i` is low, the pulse is ignored.
- R4: A pulse on `acq_done_evt_i` sets pending bit 1.
- R5: A write to offset 0 sets the mask bits where the write data has a one. Mask bits where the data has a zero keep their value.
- R6: A write to offset 1 clears the mask bits where the write data has a one. Mask bits where the data has a zero keep their value.
- R7: Reading offset 2 returns the mask in bits [1:0]. Writes to offset 2 have no effect. Reading offset 0 or 1 returns zero. All upper read bits are zero.
- R8: Reading offset 3 returns the pending bits. Writing a one to a pending bit at offset 3 clears it, and writing a zero leaves it unchanged.
- R9: An event sets its pending bit even while that source is masked. In that case `irq_o` stays low.
- R10: If an event and a clear write hit the same pending bit in the same cycle, the bit stays set.
- R11: `irq_o` equals the OR over all sources of (pending AND mask) as it was one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_evt_i | input | 1 | Trigger event pulse |
| trig_armed_i | input | 1 | High while the acquisition engine waits for a trigger |
| acq_done_evt_i | input | 1 | Acquisition-complete event pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word offset |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data (combinational from `addr_i`) |
| irq_o | output | 1 | Level interrupt to the aggregator |

## Verification
Four properties are checked on every cycle:
- The one-cycle registered relation between pending, mask and `irq_o`.
- Every accepted event is latched in its pending bit.
- A pending bit falls only under a matching clear write.
- The mask stays still in cycles without a write.

Other behaviours can only be shown by the bench's scenarios, which compare the design against a behavioural model on every clock. These are the read data at each offset, the decoding of offsets and bit positions, the trigger qualification by the armed input, writes that have no effect, and the event-versus-clear collision.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] OFS_ENABLE  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] OFS_DISABLE = 2'd1;
  localparam logic [REG_ADDR_W-1:0] OFS_MASK    = 2'd2;
  localparam logic [REG_ADDR_W-1:0] OFS_STATUS  = 2'd3;

  // Next pending vector: clears apply first, new events win.
  function automatic logic [1:0] pend_update(input logic [1:0] cur,
                                             input logic [1:0] set,
                                             input logic [1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  // Next mask vector from set/clear strobes.
  function automatic logic [1:0] mask_update(input logic [1:0] cur,
                                             input logic [1:0] on,
                                             input logic [1:0] off);
    return (cur | on) & ~off;
  endfunction
endpackage

// File: rtl/evt_irq_mask.sv
module evt_irq_mask #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] on_vec,
  input  logic [NSRC-1:0] off_vec,
  output logic [NSRC-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= (mask_q | on_vec) & ~off_vec;
  end
endmodule

// File: rtl/evt_irq_pend.sv
module evt_irq_pend #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] pend_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          pend_q[i] <= 1'b0;
      else if (set_vec[i]) pend_q[i] <= 1'b1;
      else if (clr_vec[i]) pend_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_q,
  input  logic [NSRC-1:0] mask_q,
  output logic            irq_q
);
  logic irq_next;
  assign irq_next = |(pend_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_next;
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig_evt_i,
  input  logic                  trig_armed_i,
  input  logic                  acq_done_evt_i,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  irq_o
);
  localparam int unsigned NSRC = 2;
  localparam int unsigned PAD  = DATA_W - NSRC;

  logic [NSRC-1:0] set_vec, clr_vec, on_vec, off_vec;
  logic [NSRC-1:0] mask_q, pend_q;
  logic [NSRC-1:0] wbits;

  assign wbits   = wr_data_i[NSRC-1:0];
  assign set_vec = {acq_done_evt_i, trig_evt_i & trig_armed_i};
  assign on_vec  = (wr_en_i && addr_i == OFS_ENABLE)  ? wbits : '0;
  assign off_vec = (wr_en_i && addr_i == OFS_DISABLE) ? wbits : '0;
  assign clr_vec = (wr_en_i && addr_i == OFS_STATUS)  ? wbits : '0;

  evt_irq_mask #(.NSRC(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .on_vec(on_vec), .off_vec(off_vec),
    .mask_q(mask_q));

  evt_irq_pend #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .pend_q(pend_q));

  evt_irq_out #(.NSRC(NSRC)) u_out (
    .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .mask_q(mask_q),
    .irq_q(irq_o));

  always_comb begin
    rd_data_o = '0;
    unique case (addr_i)
      OFS_MASK:   rd_data_o = {{PAD{1'b0}}, mask_q};
      OFS_STATUS: rd_data_o = {{PAD{1'b0}}, pend_q};
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
  parameter int unsigned NSRC = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en_i,
  input logic [NSRC-1:0] set_vec,
  input logic [NSRC-1:0] clr_vec,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] mask_q,
  input logic            irq_o
);
  logic seen_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_rst <= 1'b1;
  end

  // R11
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
    $past(rst_n) |-> (irq_o == $past(|(pend_q & mask_q))));

  // R9
  event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  // R8
  pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
    $past(rst_n) |-> (($past(pend_q) & ~pend_q & ~$past(clr_vec)) == '0));

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
    !wr_en_i |=> $stable(mask_q));
endmodule

bind evt_irq_ctrl evt_irq_chk #(.NSRC(2)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .set_vec(set_vec),
  .clr_vec(clr_vec), .pend_q(pend_q), .mask_q(mask_q), .irq_o(irq_o));

// File: tb/sim_evt_irq_ctrl.sv
`timescale 1ns/1ps
module sim_evt_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic trig = 0, armed = 0, done = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int checks = 0, fails = 0;
  string tag = "R1";
  int m_mask = 0, m_pend = 0, m_irq = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  evt_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .trig_evt_i(trig), .trig_armed_i(armed),
    .acq_done_evt_i(done), .wr_en_i(wr), .addr_i(addr), .wr_data_i(wdata),
    .rd_data_o(rdata), .irq_o(irq));

  task automatic chk(string t, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // behavioural reference, updated at each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = 0; m_pend = 0; m_irq = 0;
    end else begin
      int nm, np;
      m_irq = ((m_pend & m_mask) != 0) ? 1 : 0;
      nm = m_mask; np = m_pend;
      if (wr) begin
        if (addr == 0) nm = nm | (wdata & 3);
        if (addr == 1) nm = nm & ~(wdata & 3);
        if (addr == 3) np = np & ~(wdata & 3);
      end
      if (trig && armed) np = np | 1;
      if (done) np = np | 2;
      m_mask = nm; m_pend = np;
    end
    #1;
    if (rst_n) begin
      int exp_rd;
      exp_rd = (addr == 2) ? m_mask : (addr == 3) ? m_pend : 0;
      chk({tag, " irq"}, irq, m_irq);
      chk({tag, " rd"}, rdata, exp_rd);
    end
  end

  task automatic cyc(); @(negedge clk); endtask
  task automatic wreg(logic [1:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1; cyc(); wr = 0; wdata = 0;
  endtask
  task automatic rreg(logic [1:0] a, int exp, string t);
    addr = a; #0.5; chk(t, rdata, exp); cyc();
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
          checks++; fails++;
          $display("FAIL watchdog actual=timeout expected=done");
          $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
          $finish;
        end
      end
    join_none
    repeat (3) cyc(); rst_n = 1; cyc();
    tag = "R1";
    rreg(2, 0, "R1 mask after reset"); rreg(3, 0, "R1 status after reset");
    chk("R1 irq after reset", irq, 0);
    tag = "R3";
    trig = 1; armed = 0; cyc(); trig = 0; cyc();
    rreg(3, 0, "R3 unarmed trigger ignored");
    trig = 1; armed = 1; cyc(); trig = 0; armed = 0; cyc();
    rreg(3, 1, "R3 armed trigger sets bit 0 (R2)");
    tag = "R8";
    wreg(3, 0); rreg(3, 1, "R8 zero write keeps pending");
    wreg(3, 1); rreg(3, 0, "R8 one write clears pending");
    tag = "R4";
    done = 1; cyc(); done = 0;
    rreg(3, 2, "R4 acq done sets bit 1");
    tag = "R9";
    rreg(2, 0, "R9 source still masked"); chk("R9 irq stays low while masked", irq, 0);
    tag = "R5";
    wreg(0, 32'hFFFF_FFFE); chk("R11 irq not yet high", irq, 0); cyc();
    chk("R11 irq high one cycle after unmask", irq, 1);
    rreg(2, 2, "R5 enable bit1");
    wreg(0, 1); rreg(2, 3, "R5 enable bit0 keeps bit1");
    rreg(0, 0, "R7 enable offset reads zero");
    tag = "R6";
    wreg(1, 2); rreg(2, 1, "R6 disable bit1 keeps bit0"); cyc();
    chk("R6 irq low after masking", irq, 0);
    rreg(1, 0, "R7 disable offset reads zero");
    tag = "R7";
    wreg(2, 3); rreg(2, 1, "R7 mask write ignored");
    tag = "R10";
    trig = 1; armed = 1; addr = 3; wdata = 1; wr = 1; cyc();
    trig = 0; armed = 0; wr = 0; wdata = 0;
    rreg(3, 3, "R10 event beats clear"); cyc();
    chk("R11 irq high with bit0 pending and enabled", irq, 1);
    tag = "R11";
    wreg(3, 3); cyc(); cyc();
    chk("R11 irq low after clear", irq, 0);
    rreg(3, 0, "R8 both cleared");
    repeat (3) cyc();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule